// File: doc/BRIEF.md
# Dual Wiper Position Register Slave on a Two-Wire Serial Bus

This block is a slave on a two-wire serial bus (I2C-style signalling). It holds two 8-bit wiper-position registers whose outputs drive the tap multiplexers of two resistor ladders. A controller elsewhere on the chip owns the bus. It changes the positions with short write transfers and reads them back with a read transfer. Both lines are sampled on the block's own system clock. Each line passes through a synchronizer and a glitch filter before any edge or bus condition is decoded. The block drives SDA open-drain through an output-enable that pulls the line low.

The seven-bit address is a fixed code `0101` in the high four bits followed by three strap inputs. The bit after the address selects the direction. A write carries a command byte that picks register 0 (with an optional chained second byte for register 1), register 1 alone, or both registers loaded from one data byte. A read returns register 0 and then register 1.

The state machine has nine states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`, `ST_CMD`, `ST_WDATA`: each shifts in a byte on SCL rises. The eighth rise moves to `ST_ACK`.
- `ST_ACK`: on the next SCL fall, goes to `ST_ACKDRV` if the byte is accepted, and to `ST_IGNORE` otherwise.
- `ST_ACKDRV`: holds SDA low for the ninth clock. Its closing fall moves to the state stored for the next byte: `ST_CMD`, `ST_WDATA` or `ST_RDATA`.
- `ST_RDATA`: shifts a byte out on SCL falls. The fall after the last bit moves to `ST_RACK`.
- `ST_RACK`: samples the controller's acknowledge. A not-acknowledge moves to `ST_IGNORE`. An acknowledge is followed, on the next fall, by a return to `ST_RDATA`.
- `ST_IGNORE`: waits for the next bus condition.

From every state, a STOP leads to `ST_IDLE` and a START leads to `ST_ADDR`.

Top module: `dual_wiper_slave`

## Requirements
- R1: An address byte is acknowledged only when bits 7..4 equal 0101 and bits 3..1 equal `strap_i[2:0]`. On a mismatch the block never pulls SDA low for the rest of that transfer, including the acknowledge slot of every later byte.
- R2: Bit 0 of the address byte selects the direction: 0 for write (a command byte follows) and 1 for read (the block transmits).
- R3: Command 8'hA9 is acknowledged. The first data byte after it loads register 0, a second data byte loads register 1, and a third data byte is not acknowledged.
- R4: Command 8'hAA is acknowledged. Its single data byte loads register 1 only, and a second data byte is not acknowledged.
- R5: Command 8'hAF is acknowledged. Its single data byte is loaded into both registers, and a second data byte is not acknowledged.
- R6: Any other command byte is not acknowledged and leaves both registers unchanged.
- R7: A read sends register 0 and then register 1, MSB first. Each further byte that the controller acknowledges reads as 8'hFF. After a byte the controller does not acknowledge, SDA stays released.
- R8: Reset sets both registers to 8'h00 and releases SDA.
- R9: Acknowledges hold SDA low through the high phase of the ninth clock and release it at the following fall. The block changes its SDA drive only while the filtered SCL is low.
- R10: A STOP or repeated START inside a byte abandons that byte. Nothing from the abandoned byte is written, and a repeated START restarts address matching.
- R11: A pulse on either line that is shorter than `FILT_LEN` system clocks has no effect on bus decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Address strap bits compared with address bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| wiper0_o | output | 8 | Register 0 value |
| wiper1_o | output | 8 | Register 1 value |

## Verification
The embedded properties hold on every cycle. They check that the SDA drive only moves while the filtered SCL is low, that a register only changes at the eighth sampling edge of a byte received in the write-data state, that the registers read zero at reset release, that the read-acknowledge state is only entered from the transmit state, and that the filter output only follows a settled synchronized input. The scenarios are the only evidence for the rest:
- address and strap matching;
- the meaning of each command and its byte limits;
- the read order and the FFh padding;
- what aborted transfers leave behind;
- the rejection of short glitches.

These all depend on multi-byte sequences whose outcome is visible only as acknowledge bits and register values.

// File: rtl/dws_pkg.sv
package dws_pkg;
    localparam int          BYTE_W    = 8;
    localparam logic [3:0]  DEV_CODE  = 4'b0101;
    localparam logic [7:0]  CMD_POT0  = 8'hA9;
    localparam logic [7:0]  CMD_POT1  = 8'hAA;
    localparam logic [7:0]  CMD_BOTH  = 8'hAF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_ACK,
        ST_ACKDRV,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } dws_state_e;
endpackage

// File: rtl/dws_line_filter.sv
module dws_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (synced != line_o) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    line_o <= synced;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(synced) == line_o)); // R11
endmodule

// File: rtl/dws_bus_events.sv
module dws_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/dual_wiper_slave.sv
module dual_wiper_slave
    import dws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [2:0]          strap_i,
    output logic                sda_oe,
    output logic [BYTE_W-1:0]   wiper0_o,
    output logic [BYTE_W-1:0]   wiper1_o
);
    localparam int BCW = $clog2(BYTE_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        dws_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g]));
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    dws_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c));

    dws_state_e             state_q, state_d, ret_q;
    logic [BCW-1:0]         bcnt_q;
    logic [BYTE_W-2:0]      shreg_q;
    logic [BYTE_W-1:0]      byte_in, txreg_q, cmd_q, w0_q, w1_q;
    logic [1:0]             wcnt_q, ridx_q;
    logic                   ack_q, racked_q, byte_done;

    assign byte_in   = {shreg_q, sda_f};
    assign byte_done = scl_rise && (bcnt_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_c) begin
            state_d = ST_IDLE;
        end else if (start_c) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR, ST_CMD, ST_WDATA: if (byte_done) state_d = ST_ACK;
                ST_ACK:    if (scl_fall) state_d = ack_q ? ST_ACKDRV : ST_IGNORE;
                ST_ACKDRV: if (scl_fall) state_d = ret_q;
                ST_RDATA:  if (scl_fall && bcnt_q == LAST_BIT) state_d = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_f)          state_d = ST_IGNORE;
                    else if (scl_fall && racked_q)  state_d = ST_RDATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q   <= '0;
            shreg_q  <= '0;
            txreg_q  <= '1;
            cmd_q    <= '0;
            w0_q     <= '0;
            w1_q     <= '0;
            wcnt_q   <= '0;
            ridx_q   <= '0;
            ack_q    <= 1'b0;
            racked_q <= 1'b0;
            ret_q    <= ST_IDLE;
        end else if (start_c || stop_c) begin
            bcnt_q   <= '0;
            wcnt_q   <= '0;
            ack_q    <= 1'b0;
            racked_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_CMD, ST_WDATA: if (scl_rise) begin
                    shreg_q <= byte_in[BYTE_W-2:0];
                    bcnt_q  <= bcnt_q + 1'b1;
                    if (bcnt_q == LAST_BIT) begin
                        if (state_q == ST_ADDR) begin
                            ack_q <= (byte_in[7:4] == DEV_CODE) && (byte_in[3:1] == strap_i);
                            ret_q <= byte_in[0] ? ST_RDATA : ST_CMD;
                        end else if (state_q == ST_CMD) begin
                            ack_q  <= (byte_in == CMD_POT0) || (byte_in == CMD_POT1) ||
                                      (byte_in == CMD_BOTH);
                            cmd_q  <= byte_in;
                            wcnt_q <= '0;
                            ret_q  <= ST_WDATA;
                        end else begin
                            ack_q  <= 1'b0;
                            ret_q  <= ST_WDATA;
                            if (wcnt_q != 2'd3) wcnt_q <= wcnt_q + 1'b1;
                            case (cmd_q)
                                CMD_POT0: begin
                                    if (wcnt_q == 2'd0) begin w0_q <= byte_in; ack_q <= 1'b1; end
                                    else if (wcnt_q == 2'd1) begin w1_q <= byte_in; ack_q <= 1'b1; end
                                end
                                CMD_POT1: if (wcnt_q == 2'd0) begin w1_q <= byte_in; ack_q <= 1'b1; end
                                CMD_BOTH: if (wcnt_q == 2'd0) begin
                                    w0_q <= byte_in; w1_q <= byte_in; ack_q <= 1'b1;
                                end
                                default: ack_q <= 1'b0;
                            endcase
                        end
                    end
                end
                ST_ACKDRV: if (scl_fall && ret_q == ST_RDATA) begin
                    txreg_q <= w0_q;
                    ridx_q  <= 2'd1;
                    bcnt_q  <= '0;
                end
                ST_RDATA: if (scl_fall) begin
                    bcnt_q  <= bcnt_q + 1'b1;
                    txreg_q <= {txreg_q[BYTE_W-2:0], 1'b1};
                    racked_q <= 1'b0;
                end
                ST_RACK: begin
                    if (scl_rise && !sda_f) racked_q <= 1'b1;
                    if (scl_fall && racked_q) begin
                        racked_q <= 1'b0;
                        txreg_q  <= (ridx_q == 2'd1) ? w1_q : '1;
                        ridx_q   <= 2'd2;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACKDRV: sda_oe = 1'b1;
            ST_RDATA:  sda_oe = ~txreg_q[BYTE_W-1];
            default:   sda_oe = 1'b0;
        endcase
    end

    assign wiper0_o = w0_q;
    assign wiper1_o = w1_q;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f); // R9
    AST_W0_BYTE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (w0_q != $past(w0_q)) |-> ($past(scl_rise) && $past(bcnt_q) == LAST_BIT && $past(state_q) == ST_WDATA)); // R10
    AST_W1_BYTE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (w1_q != $past(w1_q)) |-> ($past(scl_rise) && $past(bcnt_q) == LAST_BIT && $past(state_q) == ST_WDATA)); // R10
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wiper0_o == '0 && wiper1_o == '0 && !sda_oe)); // R8
    AST_RACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK && $past(state_q) != ST_RACK) |-> ($past(state_q) == ST_RDATA)); // R7
endmodule

// File: tb/dual_wiper_slave_tb.sv
module dual_wiper_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 40 * CLK_PERIOD;
    localparam int QTR        = HALF / 4;
    localparam int WD_CYCLES  = 150000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] AW = {4'b0101, STRAP, 1'b0};
    localparam logic [7:0] AR = {4'b0101, STRAP, 1'b1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [7:0] wiper0, wiper1;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_wiper_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(STRAP), .sda_oe(sda_oe), .wiper0_o(wiper0), .wiper1_o(wiper1));

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];
    int   obs_q[$];
    int   n_checks = 0, n_fail = 0;

    task automatic expect_item(input string req, input int val);
        exp_t e; e.req = req; e.val = val; exp_q.push_back(e);
    endtask
    task automatic observe(input int val);
        obs_q.push_back(val);
    endtask
    task automatic chk(input string req, input int exp_v, input int got);
        expect_item(req, exp_v); observe(got);
    endtask

    always @(negedge clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            exp_t e; int o;
            e = exp_q.pop_front(); o = obs_q.pop_front();
            n_checks++;
            if (o != e.val) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", e.req, o, e.val);
            end
        end
    end

    task automatic bus_start;
        sda_m = 1'b1; #(QTR); scl_m = 1'b1; #(HALF);
        sda_m = 1'b0; #(HALF); scl_m = 1'b0; #(QTR);
    endtask
    task automatic bus_stop;
        #(QTR); sda_m = 1'b0; #(HALF - QTR); scl_m = 1'b1; #(HALF);
        sda_m = 1'b1; #(HALF);
    endtask
    task automatic put_bit(input logic b, input bit glitch);
        #(QTR); sda_m = b; #(HALF - QTR); scl_m = 1'b1; #(HALF/2);
        if (glitch) begin sda_m = ~b; #(2*CLK_PERIOD); sda_m = b; end
        #(HALF/2); scl_m = 1'b0;
    endtask
    task automatic get_bit(output logic b);
        #(QTR); sda_m = 1'b1; #(HALF - QTR); scl_m = 1'b1; #(HALF/2);
        b = sda_line; #(HALF/2); scl_m = 1'b0;
    endtask
    task automatic send_byte(input logic [7:0] d, input int glitch_bit, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(d[i], i == glitch_bit);
        get_bit(nack);
    endtask
    task automatic recv_byte(input bit master_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~master_ack, 1'b0);
    endtask
    // R9: SDA must be released shortly after the acknowledge slot ends
    task automatic check_released(input string req);
        #(QTR); sda_m = 1'b1; #(QTR); chk(req, 1, sda_line);
    endtask

    initial begin
        logic nk; logic [7:0] rd;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R8 wiper0 reset", 8'h00, wiper0);
        chk("R8 wiper1 reset", 8'h00, wiper1);
        chk("R8 sda released", 0, sda_oe);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R3: pot0 command with chained byte and an excess byte
        bus_start;
        send_byte(AW, -1, nk);   chk("R1 address ack", 0, nk);
        check_released("R9 release after ack");
        send_byte(8'hA9, -1, nk); chk("R3 cmd ack", 0, nk);
        send_byte(8'h3C, -1, nk); chk("R3 first data ack", 0, nk);
        send_byte(8'hA5, -1, nk); chk("R3 second data ack", 0, nk);
        send_byte(8'h77, -1, nk); chk("R3 third data nack", 1, nk);
        bus_stop;
        chk("R3 wiper0", 8'h3C, wiper0);
        chk("R3 wiper1", 8'hA5, wiper1);

        // R4: pot1 only
        bus_start;
        send_byte(AW, -1, nk);    chk("R2 write address ack", 0, nk);
        send_byte(8'hAA, -1, nk); chk("R4 cmd ack", 0, nk);
        send_byte(8'h5E, -1, nk); chk("R4 data ack", 0, nk);
        send_byte(8'h11, -1, nk); chk("R4 second data nack", 1, nk);
        bus_stop;
        chk("R4 wiper0 kept", 8'h3C, wiper0);
        chk("R4 wiper1", 8'h5E, wiper1);

        // R5: both from one byte
        bus_start;
        send_byte(AW, -1, nk);
        send_byte(8'hAF, -1, nk); chk("R5 cmd ack", 0, nk);
        send_byte(8'h81, -1, nk); chk("R5 data ack", 0, nk);
        send_byte(8'h22, -1, nk); chk("R5 second data nack", 1, nk);
        bus_stop;
        chk("R5 wiper0", 8'h81, wiper0);
        chk("R5 wiper1", 8'h81, wiper1);

        // R6: unknown command
        bus_start;
        send_byte(AW, -1, nk);
        send_byte(8'hAB, -1, nk); chk("R6 unknown cmd nack", 1, nk);
        send_byte(8'h00, -1, nk); chk("R6 data after unknown nack", 1, nk);
        bus_stop;
        chk("R6 wiper0 kept", 8'h81, wiper0);
        chk("R6 wiper1 kept", 8'h81, wiper1);

        // R1: wrong strap, then wrong code
        bus_start;
        send_byte({4'b0101, 3'b110, 1'b0}, -1, nk); chk("R1 strap mismatch nack", 1, nk);
        send_byte(8'hAF, -1, nk); chk("R1 ignored cmd nack", 1, nk);
        send_byte(8'h00, -1, nk); chk("R1 ignored data nack", 1, nk);
        bus_stop;
        bus_start;
        send_byte({4'b0110, STRAP, 1'b0}, -1, nk); chk("R1 code mismatch nack", 1, nk);
        bus_stop;
        chk("R1 wiper0 kept", 8'h81, wiper0);

        // R3: single byte after pot0 command
        bus_start;
        send_byte(AW, -1, nk);
        send_byte(8'hA9, -1, nk);
        send_byte(8'h12, -1, nk); chk("R3 single data ack", 0, nk);
        bus_stop;
        chk("R3 single wiper0", 8'h12, wiper0);
        chk("R3 single wiper1 kept", 8'h81, wiper1);

        // R7: read order and padding
        bus_start;
        send_byte(AR, -1, nk); chk("R2 read address ack", 0, nk);
        recv_byte(1'b1, rd);   chk("R7 read reg0", 8'h12, rd);
        recv_byte(1'b1, rd);   chk("R7 read reg1", 8'h81, rd);
        recv_byte(1'b0, rd);   chk("R7 read padding", 8'hFF, rd);
        check_released("R7 release after nack");
        bus_stop;
        bus_start;
        send_byte(AR, -1, nk);
        recv_byte(1'b0, rd);   chk("R7 single read reg0", 8'h12, rd);
        check_released("R7 release after first nack");
        bus_stop;

        // R10: STOP inside a data byte
        bus_start;
        send_byte(AW, -1, nk);
        send_byte(8'hA9, -1, nk);
        for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
        bus_stop;
        chk("R10 stop abort wiper0", 8'h12, wiper0);

        // R10: repeated START inside a data byte, then read back
        bus_start;
        send_byte(AW, -1, nk);
        send_byte(8'hAA, -1, nk);
        for (int i = 0; i < 5; i++) put_bit(1'b0, 1'b0);
        bus_start;
        send_byte(AR, -1, nk); chk("R10 restart address ack", 0, nk);
        recv_byte(1'b1, rd);   chk("R10 restart read reg0", 8'h12, rd);
        recv_byte(1'b0, rd);   chk("R10 restart read reg1", 8'h81, rd);
        bus_stop;

        // R11: short SDA glitch while SCL high inside a data byte
        bus_start;
        send_byte(AW, -1, nk);
        send_byte(8'hAA, -1, nk);
        send_byte(8'h66, 5, nk); chk("R11 glitched byte ack", 0, nk);
        bus_stop;
        chk("R11 wiper1 after glitch", 8'h66, wiper1);

        repeat (20) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_fail += exp_q.size();
            $display("FAIL scoreboard: actual %0d items unmatched expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule